// File: doc/BRIEF.md
# Overflow Interval Timer

This block is an up-counting interval timer with a small single-cycle register bus. A counter of configurable width (32 bits by default) advances by one on every clock while the timer runs. When the counter sits at its all-ones value and advances again, an overflow event occurs. The event sets a sticky status flag and, if enabled, drives the interrupt line. To get an event N+1 clocks after counting starts, software writes all-ones minus N into the counter and then sets the run bit.

Two modes follow an overflow. With the auto-reload bit clear, the timer behaves as a one-shot: the counter wraps to zero, the run bit drops and the count holds. With auto-reload set, the counter takes the reload value and keeps running, which gives a periodic tick. The reload value must be written before the timer is started. A control write with its load-now bit set copies the reload value into the counter in the same action that starts the timer.

Every register write passes through a fixed pending delay that models resynchronisation into the timer clock domain. A write takes effect a fixed number of clocks after the bus samples it. Reads are immediate and return live state. The core is a two-state controller, IDLE and RUN. IDLE goes to RUN when a control write with the run bit set takes effect. RUN goes to IDLE when a control write with the run bit clear takes effect, or when an overflow occurs with auto-reload clear. RUN stays in RUN on an overflow with auto-reload set.

Top module: `gpt_ovf_timer`

## Requirements
- R1: After reset, every register reads zero: counter, reload, control, enable and status. The interrupt output is low.
- R2: A write sampled by the bus on clock edge k takes effect on edge k+3. Until then, reads return the old value. Word addresses: 0 control, 1 reload, 2 counter, 3 interrupt enable (bit 0), 4 status (bit 0 = overflow). Other addresses read as zero.
- R3: While the timer runs, the counter increases by exactly one on each clock.
- R4: In the running state, when the counter at all-ones advances, the overflow status bit sets. With control bit 1 (auto-reload) set, the counter takes the reload value and keeps running.
- R5: When an overflow occurs with auto-reload clear, the counter becomes zero, control bit 0 (run) reads zero, and the counter then holds.
- R6: A control write with bit 0 clear freezes the counter without changing the reload register. A later control write with bit 0 set resumes counting from the frozen value.
- R7: A control write with bit 2 (load-now) set copies the reload register into the counter on the edge at which the write takes effect.
- R8: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. If an overflow and a clear take effect on the same edge, the bit stays set.
- R9: The interrupt output equals the overflow status bit ANDed with enable bit 0.
- R10: The counter is loaded with all-ones minus N, and a start write then takes effect on edge b. The overflow status then reads 1 after edge b+N+1 and 0 before it.
- R11: A counter write that takes effect while the timer runs replaces the count, and counting continues from the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on each rising edge |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Overflow interrupt, high while flag and enable are both set |

## Verification
The bench targets these corner cases:
- Overflow from all-ones. A design that is off by one edge would raise status one cycle early or late against the N+1 rule.
- The one-shot stop. A design that got it wrong would keep counting or reload.
- A status clear that lands on the same edge as a periodic overflow. A design with the wrong priority would lose a tick.
- The pending delay. A design with a short or long pipeline would show new register values on the wrong cycle.
- A counter write while running. A design that stops, or that ignores the write, diverges from the model.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int ADDR_W = 3;

    // Word addresses of the register window
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

    // Control and status bit positions
    localparam int B_RUN   = 0;
    localparam int B_AUTO  = 1;
    localparam int B_LDNOW = 2;
    localparam int B_OVF   = 0;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gpt_state_e;

endpackage

// File: rtl/gpt_wr_pipe.sv
module gpt_wr_pipe #(
    parameter int DW    = 32,
    parameter int AW    = 3,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_vld,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);

    localparam int LAST = DEPTH - 1;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;

        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld  <= 1'b0;
                    addr <= '0;
                    data <= '0;
                end else begin
                    vld  <= in_vld;
                    addr <= in_addr;
                    data <= in_data;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld  <= 1'b0;
                    addr <= '0;
                    data <= '0;
                end else begin
                    vld  <= g_stage[g-1].vld;
                    addr <= g_stage[g-1].addr;
                    data <= g_stage[g-1].data;
                end
            end
        end
    end

    assign out_vld  = g_stage[LAST].vld;
    assign out_addr = g_stage[LAST].addr;
    assign out_data = g_stage[LAST].data;

endmodule

// File: rtl/gpt_fsm.sv
module gpt_fsm
    import gpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_run,
    input  logic ctrl_auto,
    input  logic wrap,
    output logic run,
    output logic auto_rl
);

    gpt_state_e state_q, state_d;
    logic       auto_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Mode register: auto-reload follows every applied control write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       auto_q <= 1'b0;
        else if (ctrl_wr) auto_q <= ctrl_auto;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && ctrl_run) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ctrl_wr)                state_d = ctrl_run ? ST_RUN : ST_IDLE;
                else if (wrap && !auto_q)   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        run     = (state_q == ST_RUN);
        auto_rl = auto_q;
    end

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         auto_rl,
    input  logic         load_wr,
    input  logic         cnt_wr,
    input  logic         ldnow,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] load,
    output logic         wrap
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q, load_q;

    assign wrap = run && (cnt_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       load_q <= '0;
        else if (load_wr) load_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (ldnow) begin
            cnt_q <= load_q;
        end else if (run) begin
            if (wrap) cnt_q <= auto_rl ? load_q : '0;
            else      cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign load = load_q;

endmodule

// File: rtl/gpt_ovf_timer.sv
module gpt_ovf_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int SYNC_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    logic              wp_vld;
    logic [ADDR_W-1:0] wp_addr;
    logic [CNT_W-1:0]  wp_data;

    logic ctrl_wr, load_wr, cnt_wr, ien_wr, stat_wr;
    logic ldnow, stat_clr;
    logic run, auto_rl, wrap;
    logic [CNT_W-1:0] cnt, load;
    logic ien_q, ovf_st;

    gpt_wr_pipe #(
        .DW    (CNT_W),
        .AW    (ADDR_W),
        .DEPTH (SYNC_LAT)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (bus_wr),
        .in_addr  (bus_addr),
        .in_data  (bus_wdata),
        .out_vld  (wp_vld),
        .out_addr (wp_addr),
        .out_data (wp_data)
    );

    // Decode of the write that takes effect this cycle
    always_comb begin
        ctrl_wr  = wp_vld && (wp_addr == A_CTRL);
        load_wr  = wp_vld && (wp_addr == A_LOAD);
        cnt_wr   = wp_vld && (wp_addr == A_COUNT);
        ien_wr   = wp_vld && (wp_addr == A_IEN);
        stat_wr  = wp_vld && (wp_addr == A_STAT);
        ldnow    = ctrl_wr && wp_data[B_LDNOW];
        stat_clr = stat_wr && wp_data[B_OVF];
    end

    gpt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_run  (wp_data[B_RUN]),
        .ctrl_auto (wp_data[B_AUTO]),
        .wrap      (wrap),
        .run       (run),
        .auto_rl   (auto_rl)
    );

    gpt_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .auto_rl (auto_rl),
        .load_wr (load_wr),
        .cnt_wr  (cnt_wr),
        .ldnow   (ldnow),
        .wdata   (wp_data),
        .cnt     (cnt),
        .load    (load),
        .wrap    (wrap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (ien_wr) ien_q <= wp_data[0];
    end

    // Overflow flag: a new event beats a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovf_st <= 1'b0;
        else if (wrap)     ovf_st <= 1'b1;
        else if (stat_clr) ovf_st <= 1'b0;
    end

    assign irq = ovf_st & ien_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_RUN]  = run;
                bus_rdata[B_AUTO] = auto_rl;
            end
            A_LOAD:  bus_rdata = load;
            A_COUNT: bus_rdata = cnt;
            A_IEN:   bus_rdata[0] = ien_q;
            A_STAT:  bus_rdata[B_OVF] = ovf_st;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpt_sva.sv
module gpt_sva #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         auto_rl,
    input logic         wrap,
    input logic         ctrl_wr,
    input logic         cnt_wr,
    input logic         ldnow,
    input logic         stat_clr,
    input logic [W-1:0] cnt,
    input logic [W-1:0] load,
    input logic         ovf_st
);

    // R3: plain counting step
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        run && !wrap && !cnt_wr && !ldnow |=> cnt == $past(cnt) + 1'b1);

    // R4: periodic reload keeps the timer running
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && auto_rl && !cnt_wr && !ctrl_wr |=> run && cnt == $past(load));

    // R5: one-shot stops at zero
    a_r5_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && !auto_rl && !ctrl_wr && !cnt_wr |=> !run && cnt == '0);

    // R6: a stopped counter holds
    a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !cnt_wr && !ldnow |=> $stable(cnt));

    // R8: overflow always leaves the flag set
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_st);

    // R8: the flag only drops through a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_st && !stat_clr |=> ovf_st);

endmodule

bind gpt_ovf_timer gpt_sva #(.W(CNT_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .auto_rl  (auto_rl),
    .wrap     (wrap),
    .ctrl_wr  (ctrl_wr),
    .cnt_wr   (cnt_wr),
    .ldnow    (ldnow),
    .stat_clr (stat_clr),
    .cnt      (cnt),
    .load     (load),
    .ovf_st   (ovf_st)
);

// File: tb/gpt_ovf_timer_tb.sv
module gpt_ovf_timer_tb_top;

    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    vectors = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    gpt_ovf_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Behavioural reference
    logic        m_run, m_ar, m_ien, m_ovf;
    logic [31:0] m_cnt, m_load;
    logic [2:0]  qa[$];
    logic [31:0] qd[$];
    int          qdue[$];
    int          edge_no;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_ar = 0; m_ien = 0; m_ovf = 0;
            m_cnt = 0; m_load = 0; edge_no = 0;
            qa.delete(); qd.delete(); qdue.delete();
        end else begin
            logic        wr, n_run, n_ar, n_ien, n_ovf;
            logic [31:0] n_cnt, n_load, d;
            logic [2:0]  a;
            edge_no++;
            wr    = m_run && (m_cnt == ONES);
            n_cnt = m_run ? (wr ? (m_ar ? m_load : 32'd0) : m_cnt + 1) : m_cnt;
            n_run = m_run && !(wr && !m_ar);
            n_ovf = m_ovf | wr;
            n_ar  = m_ar; n_ien = m_ien; n_load = m_load;
            if (qdue.size() > 0 && qdue[0] == edge_no) begin
                a = qa.pop_front();
                d = qd.pop_front();
                void'(qdue.pop_front());
                case (a)
                    3'd0: begin n_run = d[0]; n_ar = d[1]; if (d[2]) n_cnt = m_load; end
                    3'd1: n_load = d;
                    3'd2: n_cnt = d;
                    3'd3: n_ien = d[0];
                    3'd4: if (d[0] && !wr) n_ovf = 0;
                    default: ;
                endcase
            end
            if (bus_wr) begin
                qa.push_back(bus_addr);
                qd.push_back(bus_wdata);
                qdue.push_back(edge_no + 3);
            end
            m_run = n_run; m_ar = n_ar; m_ien = n_ien; m_ovf = n_ovf;
            m_cnt = n_cnt; m_load = n_load;
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {30'd0, m_ar, m_run};
            3'd1: return m_load;
            3'd2: return m_cnt;
            3'd3: return {31'd0, m_ien};
            3'd4: return {31'd0, m_ovf};
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d);
        logic [31:0] exp_rd;
        logic        exp_irq;
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        exp_rd  = model_read(a);
        exp_irq = m_ovf & m_ien;   // R9
        vectors++;
        if (bus_rdata !== exp_rd || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: addr %0d rdata %h irq %b, expected rdata %h irq %b",
                     cur_req, a, bus_rdata, irq, exp_rd, exp_irq);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a, input int n);
        for (int i = 0; i < n; i++) step(1'b0, a, 32'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: cycle %0d reached, expected end before 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        for (int a = 0; a < 8; a++) rd(3'(a), 1);

        cur_req = "R2";
        wr(3'd1, 32'h0000_1234);
        rd(3'd1, 5);
        wr(3'd7, 32'hDEAD_BEEF);
        rd(3'd7, 4);

        cur_req = "R10";
        wr(3'd2, ONES - 32'd5);
        wr(3'd3, 32'd1);
        rd(3'd2, 3);
        wr(3'd0, 32'd1);
        cur_req = "R3";
        rd(3'd2, 4);
        cur_req = "R10";
        rd(3'd4, 6);

        cur_req = "R5";
        rd(3'd0, 2);
        rd(3'd2, 4);

        cur_req = "R8";
        wr(3'd4, 32'd0);
        rd(3'd4, 4);
        wr(3'd4, 32'd1);
        rd(3'd4, 4);

        cur_req = "R4";
        wr(3'd1, ONES - 32'd3);
        rd(3'd1, 3);
        cur_req = "R7";
        wr(3'd0, 32'd7);
        rd(3'd2, 4);
        cur_req = "R4";
        rd(3'd2, 12);
        rd(3'd4, 2);

        cur_req = "R8";
        for (int i = 0; i < 10; i++) wr(3'd4, 32'd1);
        rd(3'd4, 6);

        cur_req = "R6";
        wr(3'd0, 32'd2);
        rd(3'd2, 8);
        rd(3'd1, 2);
        wr(3'd0, 32'd3);
        rd(3'd2, 6);

        cur_req = "R11";
        wr(3'd2, ONES - 32'd20);
        rd(3'd2, 8);
        rd(3'd0, 2);

        cur_req = "R9";
        wr(3'd3, 32'd0);
        rd(3'd4, 5);
        wr(3'd3, 32'd1);
        rd(3'd4, 5);

        cur_req = "R5";
        wr(3'd0, 32'd0);
        wr(3'd2, ONES - 32'd2);
        rd(3'd2, 3);
        wr(3'd0, 32'd1);
        rd(3'd2, 10);
        rd(3'd0, 2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule